// File: doc/BRIEF.md
# Dual-Tone Alert Qualifier and Mode Control

This block sits behind the analog front end of a caller-identity receiver. It decides what drives the detect output and the active-low interrupt output, based on two mode pins. One pin selects a low-power state that keeps only the ring path alive. The other pin chooses between alert-tone listening and FSK data reception. Three indications come in from the front end:
- a per-sample "both alert tones present" flag;
- an FSK carrier-level flag;
- a ring or line-reversal level.

All three are synchronised to the system clock before use.

In alert-tone mode the detect output follows the tone flag. The block measures, in millisecond ticks, how long the detect output stays high. When it falls, an interrupt is latched only if that length lies inside a parameterised qualification window. The interrupt then holds until the mode changes. In FSK mode the carrier flag is smoothed by time hysteresis: separate on-delays and off-delays, counted in whole milliseconds, suppress chatter. Millisecond ticks come from a prescaler on the system clock.

Top module: `alert_qual_top`

## Requirements
- R1: After reset, with mode pins low and all indications low, detOut is 0 and irqN is 1.
- R2: In alert-tone mode (zeroPwr=0, modeSel=0), detOut equals toneHit delayed by the two-flop synchroniser.
- R3: In alert-tone mode, when detOut falls after a high time of N whole ms ticks, with QUAL_MIN_MS <= N <= QUAL_MAX_MS, irqN goes low on the following clock.
- R4: A high time of fewer than QUAL_MIN_MS ticks never pulls irqN low.
- R5: A high time of more than QUAL_MAX_MS ticks never pulls irqN low. The duration counter saturates, so very long bursts cannot wrap into the window.
- R6: Once low in alert-tone mode, irqN stays low through later bursts of any length. Leaving alert-tone mode releases it, and it is still clear on return.
- R7: In FSK mode (zeroPwr=0, modeSel=1), detOut rises after fskLevel has been high for FSK_ON_MS consecutive ticks. It falls after fskLevel has been low for FSK_OFF_MS consecutive ticks. Shorter excursions leave detOut unchanged.
- R8: In FSK mode, irqN is low while retimeReq is 1 or the synchronised ringHit is 1.
- R9: In low-power mode (zeroPwr=1), irqN is the inverse of the synchronised ringHit. detOut equals that ringHit when modeSel=0 and is 0 when modeSel=1. toneHit and fskLevel have no effect.
- R10: Any mode change clears the duration count. Ticks before the change do not count toward a burst that ends after a return to alert-tone mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| zeroPwr | input | 1 | 1 selects low-power mode (ring path only) |
| modeSel | input | 1 | 0 = alert-tone listening, 1 = FSK reception |
| toneHit | input | 1 | Asynchronous flag: both alert tones present |
| fskLevel | input | 1 | Asynchronous FSK carrier level above threshold |
| ringHit | input | 1 | Asynchronous ring / line-reversal level |
| retimeReq | input | 1 | Synchronous request from the data retimer |
| detOut | output | 1 | Detect output, source chosen by mode |
| irqN | output | 1 | Active-low interrupt, source chosen by mode |

## Verification
The pin-to-output delays differ by source:

| Result | Due |
|--------|-----|
| detOut from toneHit or ringHit | 2 clocks (synchroniser) |
| Output source after a mode-pin change | 1 clock |
| irqN from retimeReq | same cycle |
| Qualified interrupt | 1 clock after detOut falls |
| FSK hysteresis flip | On the tick that completes the count, plus 2 synchroniser clocks |

Every stimulus is driven on a falling clock edge, and outputs are sampled on falling edges at least four clocks after the latest due point. Burst lengths are exact multiples of the tick period. Because of this, the measured tick count equals the intended length whatever the prescaler phase, so the window edges (one below, on, and one above each bound) give deterministic results.

// File: rtl/alert_qual_pkg.sv
package alert_qual_pkg;

  // Operating state decoded from the two mode pins
  typedef enum logic [1:0] {
    MODE_TONE     = 2'd0,
    MODE_FSK      = 2'd1,
    MODE_ZP_RING  = 2'd2,
    MODE_ZP_QUIET = 2'd3
  } opModeT;

  // Strobes from control to datapath
  typedef struct packed {
    logic clrQual;   // clear duration counter and latched interrupt
    logic clrHyst;   // clear FSK level hysteresis
    logic detRise;   // tone detect rising this cycle
    logic detFall;   // tone detect falling this cycle
  } dpStrobeT;

endpackage

// File: rtl/alert_qual_dp.sv
module alert_qual_dp
  import alert_qual_pkg::*;
#(
  parameter int CLKS_PER_MS = 250000,
  parameter int QUAL_MIN_MS = 10,
  parameter int QUAL_MAX_MS = 45,
  parameter int FSK_ON_MS   = 20,
  parameter int FSK_OFF_MS  = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     toneRaw,
  input  logic     ringRaw,
  input  logic     fskRaw,
  input  dpStrobeT strobe,
  output logic     toneSync,
  output logic     ringSync,
  output logic     fskDet,
  output logic     irqLatch,
  output logic     msTick
);

  localparam int PRE_W    = (CLKS_PER_MS > 1) ? $clog2(CLKS_PER_MS) : 1;
  localparam int DUR_W    = $clog2(QUAL_MAX_MS + 2);
  localparam int HYS_MAX  = (FSK_ON_MS > FSK_OFF_MS) ? FSK_ON_MS : FSK_OFF_MS;
  localparam int HYS_W    = $clog2(HYS_MAX + 1);
  localparam int N_SYNC   = 3;
  localparam logic [DUR_W-1:0] DUR_SAT = '1;
  localparam logic [DUR_W-1:0] QMIN    = DUR_W'(QUAL_MIN_MS);
  localparam logic [DUR_W-1:0] QMAX    = DUR_W'(QUAL_MAX_MS);
  localparam logic [PRE_W-1:0] PRE_TOP = PRE_W'(CLKS_PER_MS - 1);

  // ---------------- input synchronisers ----------------
  logic [N_SYNC-1:0] rawVec;
  logic [N_SYNC-1:0] syncVec;
  logic              fskSync;

  assign rawVec = {fskRaw, ringRaw, toneRaw};

  genvar g;
  generate
    for (g = 0; g < N_SYNC; g++) begin : gSync
      logic [SYNC_STAGES-1:0] shReg;
      if (SYNC_STAGES == 1) begin : gOne
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) shReg <= '0;
          else       shReg <= rawVec[g];
      end else begin : gMany
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) shReg <= '0;
          else       shReg <= {shReg[SYNC_STAGES-2:0], rawVec[g]};
      end
      assign syncVec[g] = shReg[SYNC_STAGES-1];
    end
  endgenerate

  assign toneSync = syncVec[0];
  assign ringSync = syncVec[1];
  assign fskSync  = syncVec[2];

  // ---------------- millisecond prescaler ----------------
  logic [PRE_W-1:0] preCnt;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)            preCnt <= '0;
    else if (msTick)      preCnt <= '0;
    else                  preCnt <= preCnt + 1'b1;

  assign msTick = (preCnt == PRE_TOP);

  // ---------------- burst duration and interrupt latch ----------------
  logic [DUR_W-1:0] durCnt;
  logic             inWindow;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)                                          durCnt <= '0;
    else if (strobe.clrQual)                            durCnt <= '0;
    else if (strobe.detRise)                            durCnt <= msTick ? DUR_W'(1) : '0;
    else if (toneSync && msTick && durCnt != DUR_SAT)   durCnt <= durCnt + 1'b1;

  assign inWindow = (durCnt >= QMIN) && (durCnt <= QMAX);

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)                             irqLatch <= 1'b0;
    else if (strobe.clrQual)               irqLatch <= 1'b0;
    else if (strobe.detFall && inWindow)   irqLatch <= 1'b1;

  // ---------------- FSK level hysteresis ----------------
  logic [HYS_W-1:0] hystCnt;
  logic [HYS_W-1:0] hystLim;

  assign hystLim = fskDet ? HYS_W'(FSK_OFF_MS - 1) : HYS_W'(FSK_ON_MS - 1);

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      hystCnt <= '0;
      fskDet  <= 1'b0;
    end else if (strobe.clrHyst) begin
      hystCnt <= '0;
      fskDet  <= 1'b0;
    end else if (fskSync == fskDet) begin
      hystCnt <= '0;
    end else if (msTick) begin
      if (hystCnt == hystLim) begin
        fskDet  <= ~fskDet;
        hystCnt <= '0;
      end else begin
        hystCnt <= hystCnt + 1'b1;
      end
    end

  // ---------------- assertions ----------------
  p_irq_on_fall_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqLatch) |-> $past(strobe.detFall));

  p_irq_window_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqLatch) |-> ($past(durCnt) >= QMIN && $past(durCnt) <= QMAX));

  p_dur_saturate_r5: assert property (@(posedge clk) disable iff (!rstN)
    (durCnt == DUR_SAT && !strobe.clrQual && !strobe.detRise) |=> durCnt == DUR_SAT);

  p_fsk_on_tick_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!msTick && !strobe.clrHyst) |=> $stable(fskDet));

endmodule

// File: rtl/alert_qual_ctrl.sv
module alert_qual_ctrl
  import alert_qual_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     zeroPwr,
  input  logic     modeSel,
  input  logic     retimeReq,
  input  logic     toneSync,
  input  logic     ringSync,
  input  logic     fskDet,
  input  logic     irqLatch,
  output dpStrobeT strobe,
  output logic     detOut,
  output logic     irqN
);

  opModeT modeNext, modeQ, modePrev;
  logic   modeChg;
  logic   tonePrev;

  always_comb begin
    if (zeroPwr) modeNext = modeSel ? MODE_ZP_QUIET : MODE_ZP_RING;
    else         modeNext = modeSel ? MODE_FSK      : MODE_TONE;
  end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      modeQ    <= MODE_TONE;
      modePrev <= MODE_TONE;
      tonePrev <= 1'b0;
    end else begin
      modeQ    <= modeNext;
      modePrev <= modeQ;
      tonePrev <= toneSync;
    end

  assign modeChg = (modeQ != modePrev);

  always_comb begin
    strobe.clrQual = modeChg || (modeQ != MODE_TONE);
    strobe.clrHyst = modeChg || (modeQ != MODE_FSK);
    strobe.detRise = toneSync && !tonePrev;
    strobe.detFall = !toneSync && tonePrev;
  end

  always_comb begin
    unique case (modeQ)
      MODE_TONE: begin
        detOut = toneSync;
        irqN   = !irqLatch;
      end
      MODE_FSK: begin
        detOut = fskDet;
        irqN   = !(retimeReq || ringSync);
      end
      MODE_ZP_RING: begin
        detOut = ringSync;
        irqN   = !ringSync;
      end
      default: begin
        detOut = 1'b0;
        irqN   = !ringSync;
      end
    endcase
  end

  p_irq_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == MODE_TONE && !irqN) |=> (!irqN || modeQ != MODE_TONE));

  p_irq_after_det_r3: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == MODE_TONE && $past(modeQ) == MODE_TONE && $fell(irqN)) |-> !detOut);

endmodule

// File: rtl/alert_qual_top.sv
module alert_qual_top
  import alert_qual_pkg::*;
#(
  parameter int CLKS_PER_MS = 250000,
  parameter int QUAL_MIN_MS = 10,
  parameter int QUAL_MAX_MS = 45,
  parameter int FSK_ON_MS   = 20,
  parameter int FSK_OFF_MS  = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic zeroPwr,
  input  logic modeSel,
  input  logic toneHit,
  input  logic fskLevel,
  input  logic ringHit,
  input  logic retimeReq,
  output logic detOut,
  output logic irqN
);

  dpStrobeT strobe;
  logic     toneSync, ringSync, fskDet, irqLatch, msTick;

  alert_qual_dp #(
    .CLKS_PER_MS(CLKS_PER_MS), .QUAL_MIN_MS(QUAL_MIN_MS), .QUAL_MAX_MS(QUAL_MAX_MS),
    .FSK_ON_MS(FSK_ON_MS), .FSK_OFF_MS(FSK_OFF_MS), .SYNC_STAGES(SYNC_STAGES)
  ) i_dp (
    .clk(clk), .rstN(rstN),
    .toneRaw(toneHit), .ringRaw(ringHit), .fskRaw(fskLevel),
    .strobe(strobe),
    .toneSync(toneSync), .ringSync(ringSync), .fskDet(fskDet),
    .irqLatch(irqLatch), .msTick(msTick)
  );

  alert_qual_ctrl i_ctrl (
    .clk(clk), .rstN(rstN),
    .zeroPwr(zeroPwr), .modeSel(modeSel), .retimeReq(retimeReq),
    .toneSync(toneSync), .ringSync(ringSync), .fskDet(fskDet), .irqLatch(irqLatch),
    .strobe(strobe), .detOut(detOut), .irqN(irqN)
  );

endmodule

// File: tb/test_alert_qual_top.sv
module test_alert_qual_top;

  localparam int CPM  = 8;
  localparam int QMIN = 10;
  localparam int QMAX = 45;
  localparam int NVEC = 8;

  // {burst length in ms, interrupt expected}
  localparam int VEC [NVEC][2] = '{
    '{5, 0}, '{9, 0}, '{10, 1}, '{20, 1}, '{45, 1}, '{46, 0}, '{70, 0}, '{80, 0}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic zeroPwr = 1'b0, modeSel = 1'b0, toneHit = 1'b0, fskLevel = 1'b0;
  logic ringHit = 1'b0, retimeReq = 1'b0;
  logic detOut, irqN;
  int   nChecks = 0, nFail = 0;
  bit   done = 1'b0;

  always #2 clk = ~clk;

  alert_qual_top #(
    .CLKS_PER_MS(CPM), .QUAL_MIN_MS(QMIN), .QUAL_MAX_MS(QMAX),
    .FSK_ON_MS(20), .FSK_OFF_MS(5), .SYNC_STAGES(2)
  ) i_alert_qual_top (
    .clk(clk), .rstN(rstN), .zeroPwr(zeroPwr), .modeSel(modeSel),
    .toneHit(toneHit), .fskLevel(fskLevel), .ringHit(ringHit),
    .retimeReq(retimeReq), .detOut(detOut), .irqN(irqN)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setMode(input logic zp, input logic md);
    @(negedge clk);
    zeroPwr = zp;
    modeSel = md;
    waitN(3);
  endtask

  // Tone high for exactly ms*CPM cycles; detOut checked mid-burst (R2)
  task automatic burst(input int ms);
    @(negedge clk);
    toneHit = 1'b1;
    waitN(4);
    check(detOut == 1'b1, "R2 det high in burst", detOut, 1);
    waitN(ms * CPM - 4);
    toneHit = 1'b0;
    waitN(4);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    waitN(5);
    rstN = 1'b1;
    waitN(3);
    // R1: reset state
    check(detOut == 1'b0, "R1 det after reset", detOut, 0);
    check(irqN == 1'b1, "R1 irqN after reset", irqN, 1);

    // Table walk: R3 in window, R4 short, R5 long
    for (int i = 0; i < NVEC; i++) begin
      setMode(1'b0, 1'b1);
      setMode(1'b0, 1'b0);
      burst(VEC[i][0]);
      check(detOut == 1'b0, "R2 det low after burst", detOut, 0);
      if (VEC[i][1] == 1)
        check(irqN == 1'b0, $sformatf("R3 qualified %0d ms", VEC[i][0]), irqN, 0);
      else if (VEC[i][0] < QMIN)
        check(irqN == 1'b1, $sformatf("R4 short %0d ms", VEC[i][0]), irqN, 1);
      else
        check(irqN == 1'b1, $sformatf("R5 long %0d ms", VEC[i][0]), irqN, 1);
    end

    // R6: latch holds through later bursts, released by mode change
    setMode(1'b0, 1'b1);
    setMode(1'b0, 1'b0);
    burst(20);
    check(irqN == 1'b0, "R6 latched", irqN, 0);
    burst(5);
    check(irqN == 1'b0, "R6 holds after short burst", irqN, 0);
    burst(60);
    check(irqN == 1'b0, "R6 holds after long burst", irqN, 0);
    setMode(1'b0, 1'b1);
    check(irqN == 1'b1, "R6 released in FSK mode", irqN, 1);
    setMode(1'b0, 1'b0);
    check(irqN == 1'b1, "R6 clear on return", irqN, 1);

    // R10: mode change mid-burst restarts the count
    @(negedge clk);
    toneHit = 1'b1;
    waitN(20 * CPM);
    setMode(1'b0, 1'b1);
    setMode(1'b0, 1'b0);
    waitN(5 * CPM);
    toneHit = 1'b0;
    waitN(4);
    check(irqN == 1'b1, "R10 count cleared by mode change", irqN, 1);

    // R7: FSK level hysteresis
    setMode(1'b0, 1'b1);
    fskLevel = 1'b1;
    waitN(10 * CPM);
    check(detOut == 1'b0, "R7 short level ignored", detOut, 0);
    fskLevel = 1'b0;
    waitN(2 * CPM);
    fskLevel = 1'b1;
    waitN(25 * CPM);
    check(detOut == 1'b1, "R7 det rises", detOut, 1);
    fskLevel = 1'b0;
    waitN(2 * CPM);
    fskLevel = 1'b1;
    waitN(4);
    check(detOut == 1'b1, "R7 short drop ignored", detOut, 1);
    fskLevel = 1'b0;
    waitN(8 * CPM);
    check(detOut == 1'b0, "R7 det falls", detOut, 0);

    // R8: FSK interrupt sources
    check(irqN == 1'b1, "R8 idle", irqN, 1);
    retimeReq = 1'b1;
    waitN(1);
    check(irqN == 1'b0, "R8 retimer request", irqN, 0);
    retimeReq = 1'b0;
    ringHit = 1'b1;
    waitN(4);
    check(irqN == 1'b0, "R8 ring in FSK mode", irqN, 0);
    ringHit = 1'b0;
    waitN(4);

    // R9: low-power modes
    setMode(1'b1, 1'b0);
    toneHit = 1'b1;
    fskLevel = 1'b1;
    waitN(30 * CPM);
    check(detOut == 1'b0, "R9 tone/level ignored det", detOut, 0);
    check(irqN == 1'b1, "R9 tone/level ignored irq", irqN, 1);
    ringHit = 1'b1;
    waitN(4);
    check(detOut == 1'b1, "R9 ring on det", detOut, 1);
    check(irqN == 1'b0, "R9 ring on irq", irqN, 0);
    setMode(1'b1, 1'b1);
    check(detOut == 1'b0, "R9 quiet det", detOut, 0);
    check(irqN == 1'b0, "R9 quiet irq", irqN, 0);
    ringHit = 1'b0;
    waitN(4);
    check(irqN == 1'b1, "R9 ring off irq", irqN, 1);
    toneHit = 1'b0;
    fskLevel = 1'b0;

    done = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule